// File: doc/BRIEF.md
# Two-Channel Disk Interrupt Status and Mask Register Block

This block keeps the interrupt state of a disk controller with two channels. Each channel has a sticky pending flag, which a rising edge on that channel's device interrupt line sets, and a block flag that keeps the pending flag away from the host. The block merges the two channels into one interrupt output for the host. For each channel it also reports whether a raised interrupt belongs to that channel, which is true when the pending flag and the channel's DMA status interrupt flag are both set.

Software reaches the state through a byte-wide register port. A single address serves reads and writes, and reads are combinational. Three registers are decoded:

- A control register that holds both pending flags, both block flags and a write-only line-read enable.
- A legacy status byte that mirrors the channel 0 pending flag.
- A secondary timing byte that mirrors the channel 1 pending flag and also stores ordinary timing fields.

Each pending flag can be seen at two addresses. A write of 1 clears it at either address. The register port is a control interface. It has no handshake, and every write takes effect in the cycle in which `reg_we` is sampled high.

Top module: `chirq_ctrl`

## Requirements
- R1: After reset, both pending flags, both block flags, the stored timing fields and the line-read enable are 0. Every decoded register reads 0, and `host_irq` and `ch_irq_own` are 0.
- R2: A low-to-high change on `dev_irq[c]` sets pending flag c at the next clock edge. A line that stays high does not set the flag again once it has been cleared.
- R3: The control register at address 2 reads as follows: bit 2 is pending 0, bit 3 is pending 1, bit 4 is block 0 and bit 5 is block 1. All other bits read 0. A write to this address loads block 0 from bit 4 and block 1 from bit 5.
- R4: The legacy status byte at address 0 reads pending 0 at bit 2 and 0 at every other bit.
- R5: The secondary timing byte at address 1 reads pending 1 at bit 4. Bits 7:6, 3 and 2 read back as last written. All other bits read 0.
- R6: Writing 1 clears a pending flag at either of its addresses: control bit 2 or legacy bit 2 for channel 0, and control bit 3 or timing bit 4 for channel 1. Writing 0 to those bits leaves the flag unchanged.
- R7: A single write to the secondary timing byte stores its read/write fields. In the same write, bit 4 acts only as a write-1-to-clear for pending 1.
- R8: Control register bit 1 drives `rd_line_en` from the last write to address 2, and this bit always reads as 0.
- R9: `host_irq` is high when some channel has its pending flag set and its block flag clear.
- R10: `ch_irq_own[c]` is high exactly when pending flag c and `dma_irq_flag[c]` are both high.
- R11: When a rising edge and a write-1 clear reach the same channel in the same clock, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_irq | input | 2 | Device interrupt line for each channel |
| dma_irq_flag | input | 2 | DMA status interrupt flag for each channel |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Register address used for both read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data at `reg_addr` |
| host_irq | output | 1 | Combined interrupt to the host |
| ch_irq_own | output | 2 | Channel owns a raised interrupt |
| rd_line_en | output | 1 | Line-read enable, write-only bit |

## Verification
The edge and clear properties assume that `dev_irq` changes only between clock edges and that no edge is present on the same channel when a plain clear is expected. For this reason the clear checks are qualified on the interrupt line being low. The stimulus changes inputs only on the falling clock edge and holds each device line steady across the read that follows, so that every edge is seen in exactly one cycle. The one case that deliberately combines an edge with a clear is the priority scenario, where the set must survive.

// File: rtl/chirq_pkg.sv
package chirq_pkg;
  localparam int unsigned NUM_CH     = 2;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned ADDR_W_DEF = 2;

  localparam logic [ADDR_W_DEF-1:0] A_LEGACY = 2'd0;
  localparam logic [ADDR_W_DEF-1:0] A_SECT   = 2'd1;
  localparam logic [ADDR_W_DEF-1:0] A_CTRL   = 2'd2;

  // control register bit positions
  localparam int unsigned B_RDLINE = 1;
  localparam int unsigned B_PEND0  = 2;
  localparam int unsigned B_PEND1  = 3;
  localparam int unsigned B_BLK0   = 4;
  localparam int unsigned B_BLK1   = 5;
  // mirror positions
  localparam int unsigned B_LEG_PEND  = 2;
  localparam int unsigned B_SECT_PEND = 4;
  // stored read/write fields of the secondary timing byte
  localparam logic [DATA_W-1:0] SECT_RW_MASK = 8'hCC;
endpackage

// File: rtl/chirq_edge.sv
module chirq_edge #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) prev_q[i] <= 1'b0;
      else        prev_q[i] <= lvl[i];
    end
    assign rise[i] = lvl[i] & ~prev_q[i];
  end
endmodule

// File: rtl/chirq_pend.sv
module chirq_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  // a set in the same cycle as a clear takes priority
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= 1'b0;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end
endmodule

// File: rtl/chirq_regs.sv
module chirq_regs
  import chirq_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_CH-1:0] pend,
  output logic [NUM_CH-1:0] clr,
  output logic [NUM_CH-1:0] blk,
  output logic              rdline,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] AL = ADDR_W'(A_LEGACY);
  localparam logic [ADDR_W-1:0] AS = ADDR_W'(A_SECT);
  localparam logic [ADDR_W-1:0] AC = ADDR_W'(A_CTRL);

  logic              hit_leg, hit_sect, hit_ctrl;
  logic [DATA_W-1:0] sect_q;

  assign hit_leg  = we && (addr == AL);
  assign hit_sect = we && (addr == AS);
  assign hit_ctrl = we && (addr == AC);

  assign clr[0] = (hit_leg  && wdata[B_LEG_PEND])  || (hit_ctrl && wdata[B_PEND0]);
  assign clr[1] = (hit_sect && wdata[B_SECT_PEND]) || (hit_ctrl && wdata[B_PEND1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk    <= '0;
      rdline <= 1'b0;
      sect_q <= '0;
    end else begin
      if (hit_ctrl) begin
        blk[0] <= wdata[B_BLK0];
        blk[1] <= wdata[B_BLK1];
        rdline <= wdata[B_RDLINE];
      end
      if (hit_sect) sect_q <= wdata & SECT_RW_MASK;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == AL) begin
      rdata[B_LEG_PEND] = pend[0];
    end else if (addr == AS) begin
      rdata = sect_q;
      rdata[B_SECT_PEND] = pend[1];
    end else if (addr == AC) begin
      rdata[B_PEND0] = pend[0];
      rdata[B_PEND1] = pend[1];
      rdata[B_BLK0]  = blk[0];
      rdata[B_BLK1]  = blk[1];
    end
  end
endmodule

// File: rtl/chirq_ctrl.sv
module chirq_ctrl
  import chirq_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        dev_irq,
  input  logic [1:0]        dma_irq_flag,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              host_irq,
  output logic [1:0]        ch_irq_own,
  output logic              rd_line_en
);
  logic [NUM_CH-1:0] rise, clr, pend_q, blk;

  chirq_edge #(.W(NUM_CH)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(dev_irq), .rise(rise)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    chirq_pend u_pend (
      .clk(clk), .rst_n(rst_n), .set_i(rise[c]), .clr_i(clr[c]), .q(pend_q[c])
    );
  end

  chirq_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .pend(pend_q), .clr(clr), .blk(blk), .rdline(rd_line_en), .rdata(reg_rdata)
  );

  assign host_irq   = |(pend_q & ~blk);
  assign ch_irq_own = pend_q & dma_irq_flag;
endmodule

// File: rtl/chirq_ctrl_chk.sv
module chirq_ctrl_chk #(
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        dev_irq,
  input logic [1:0]        dma_irq_flag,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        reg_wdata,
  input logic [7:0]        reg_rdata,
  input logic              host_irq,
  input logic [1:0]        ch_irq_own,
  input logic [1:0]        pend,
  input logic [1:0]        blk
);
  localparam logic [ADDR_W-1:0] AL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] AS = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] AC = ADDR_W'(2);

  AST_EDGE_SETS_PEND0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_irq[0]) |=> pend[0]); // R2
  AST_EDGE_SETS_PEND1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_irq[1]) |=> pend[1]); // R2
  AST_W1C_CTRL_CH0: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == AC && reg_wdata[2] && !dev_irq[0]) |=> !pend[0]); // R6
  AST_W1C_SECT_CH1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == AS && reg_wdata[4] && !dev_irq[1]) |=> !pend[1]); // R7
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dev_irq[0]) && reg_we && reg_addr == AC && reg_wdata[2]) |=> pend[0]); // R11
  AST_NO_PEND_NO_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == 2'b00) |-> !host_irq); // R9
  AST_ALL_BLOCKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (blk == 2'b11) |-> !host_irq); // R9
  AST_OWN_NEEDS_DMA: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_irq_flag == 2'b00) |-> (ch_irq_own == 2'b00)); // R10
  AST_RDLINE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == AC) |-> !reg_rdata[1]); // R8
  AST_LEGACY_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == AL) |-> (reg_rdata[2] == pend[0])); // R4
endmodule

bind chirq_ctrl chirq_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .dma_irq_flag(dma_irq_flag),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .host_irq(host_irq), .ch_irq_own(ch_irq_own),
  .pend(pend_q), .blk(blk)
);

// File: tb/test_chirq_ctrl.sv
module test_chirq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] dev_irq, dma_irq_flag;
  logic       reg_we;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       host_irq, rd_line_en;
  logic [1:0] ch_irq_own;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  chirq_ctrl i_chirq_ctrl (
    .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .dma_irq_flag(dma_irq_flag),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .host_irq(host_irq), .ch_irq_own(ch_irq_own),
    .rd_line_en(rd_line_en)
  );

  typedef struct packed {
    logic [1:0] dev;
    logic [1:0] dma;
    logic       we;
    logic [1:0] wa;
    logic [7:0] wd;
    logic [1:0] ra;
    logic [7:0] exp_rd;
    logic       exp_host;
    logic [1:0] exp_own;
  } vec_t;

  localparam int NV = 15;
  // addresses: 0 legacy, 1 secondary timing, 2 control
  localparam vec_t VEC [NV] = '{
    '{2'b00, 2'b00, 1'b0, 2'd0, 8'h00, 2'd2, 8'h00, 1'b0, 2'b00}, // idle R3
    '{2'b01, 2'b00, 1'b0, 2'd0, 8'h00, 2'd2, 8'h04, 1'b1, 2'b00}, // edge ch0 R2
    '{2'b01, 2'b01, 1'b0, 2'd0, 8'h00, 2'd0, 8'h04, 1'b1, 2'b01}, // mirror R4 R10
    '{2'b01, 2'b01, 1'b1, 2'd2, 8'h10, 2'd2, 8'h14, 1'b0, 2'b01}, // block0 R9 R6
    '{2'b11, 2'b00, 1'b0, 2'd0, 8'h00, 2'd1, 8'h10, 1'b1, 2'b00}, // edge ch1 R5
    '{2'b11, 2'b10, 1'b1, 2'd1, 8'hCC, 2'd1, 8'hDC, 1'b1, 2'b10}, // fields R7
    '{2'b11, 2'b10, 1'b1, 2'd1, 8'h10, 2'd1, 8'h00, 1'b0, 2'b00}, // w1c ch1 R7
    '{2'b11, 2'b00, 1'b0, 2'd0, 8'h00, 2'd2, 8'h14, 1'b0, 2'b00}, // no re-set R2
    '{2'b11, 2'b00, 1'b1, 2'd2, 8'h02, 2'd2, 8'h04, 1'b1, 2'b00}, // rdline R8
    '{2'b11, 2'b00, 1'b1, 2'd0, 8'h04, 2'd2, 8'h00, 1'b0, 2'b00}, // legacy w1c R6
    '{2'b00, 2'b00, 1'b1, 2'd2, 8'h30, 2'd2, 8'h30, 1'b0, 2'b00}, // block both R3
    '{2'b11, 2'b11, 1'b0, 2'd0, 8'h00, 2'd2, 8'h3C, 1'b0, 2'b11}, // both blocked R9
    '{2'b11, 2'b00, 1'b1, 2'd2, 8'h0C, 2'd2, 8'h00, 1'b0, 2'b00}, // ctrl w1c R6
    '{2'b00, 2'b00, 1'b0, 2'd0, 8'h00, 2'd2, 8'h00, 1'b0, 2'b00}, // quiet
    '{2'b01, 2'b00, 1'b1, 2'd2, 8'h04, 2'd2, 8'h04, 1'b1, 2'b00}  // set wins R11
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input vec_t v, input int idx);
    @(negedge clk);
    dev_irq = v.dev; dma_irq_flag = v.dma;
    reg_we = v.we; reg_addr = v.wa; reg_wdata = v.wd;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = v.ra;
    #1;
    check($sformatf("R3/R4/R5 vec%0d rdata", idx), reg_rdata, v.exp_rd);
    check($sformatf("R9 vec%0d host_irq", idx), {7'd0, host_irq}, {7'd0, v.exp_host});
    check($sformatf("R10 vec%0d own", idx), {6'd0, ch_irq_own}, {6'd0, v.exp_own});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; dev_irq = '0; dma_irq_flag = '0;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state at every address
    for (int a = 0; a < 3; a++) begin
      reg_addr = 2'(a); #1;
      check($sformatf("R1 reset addr%0d", a), reg_rdata, 8'h00);
    end
    check("R1 reset host_irq", {7'd0, host_irq}, 8'h00);
    check("R1 reset own", {6'd0, ch_irq_own}, 8'h00);
    check("R1 reset rd_line_en", {7'd0, rd_line_en}, 8'h00);

    for (int i = 0; i < NV; i++) step(VEC[i], i);

    // R8: bit 1 drives rd_line_en and reads back 0
    @(negedge clk); dev_irq = 2'b00; reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h02;
    @(negedge clk); reg_we = 1'b0; #1;
    check("R8 rd_line_en set", {7'd0, rd_line_en}, 8'h01);
    check("R8 bit1 reads 0", {7'd0, reg_rdata[1]}, 8'h00);
    @(negedge clk); reg_we = 1'b1; reg_wdata = 8'h00;
    @(negedge clk); reg_we = 1'b0; #1;
    check("R8 rd_line_en cleared", {7'd0, rd_line_en}, 8'h00);

    // R6: zero write to the legacy byte leaves pending 0 set
    @(negedge clk); dev_irq = 2'b01;
    @(negedge clk); reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 8'hFB;
    @(negedge clk); reg_we = 1'b0; #1;
    check("R6 zero write keeps pend0", reg_rdata, 8'h04);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule